// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the real outcomes of the most recent branches, with 1 for taken and 0 for not taken. That value selects one entry of a shared table of 2-bit saturating counters. A front-end stage raises a request and gets back the guess one cycle later. With the guess it also gets the table index that was used. Branch address bits play no part in the lookup.

When the execute stage knows the real outcome, it presents that outcome on the resolve port together with the index it was given at prediction time. The block then trains that one counter and shifts the outcome into the history. Training therefore lands on the right entry even when later branches have already moved the history on. The history length is a parameter with a default of 8, so the table holds 256 counters. All state sits in flip-flops: the history bits plus two bits per entry.

Top module: `gh_predictor`

## Requirements
- R1: `pred_valid` is high in the cycle after each cycle with `pred_req` high, and low in the cycle after each cycle with `pred_req` low.
- R2: A returned guess is taken (`pred_taken`=1) when the selected counter holds 2 or 3, and not taken when it holds 0 or 1.
- R3: After reset every counter holds 1 and the history is 0, so the first request returns not taken with index 0.
- R4: A resolved taken outcome raises the addressed counter by one, stopping at 3. A resolved not-taken outcome lowers it by one, stopping at 0.
- R5: On each cycle with `res_valid` high, the history shifts left by one and `res_taken` enters at bit 0. Without `res_valid` the history holds.
- R6: The table index used for a request equals the history value, with bit 0 the newest outcome, and it is returned on `pred_index`. For example, history 0x2E returns index 46.
- R7: Training writes the counter named by `res_index`, whatever the current history is.
- R8: When a request and a resolve occur in the same cycle, the request uses the history and counter values from before that resolve.
- R9: A counter in a strong state changes its guess only after two outcomes in a row that disagree with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_req | input | 1 | Request a direction guess |
| pred_valid | output | 1 | Registered: guess is present this cycle |
| pred_taken | output | 1 | Registered: guessed direction, 1 = taken |
| pred_index | output | HIST_LEN | Registered: table index used for the guess |
| res_valid | input | 1 | A branch outcome is being reported |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_index | input | HIST_LEN | Index returned when that branch was predicted |

## Verification
A wrong history value shows up in the very next `pred_index` after a request, because the index is the history itself. A single missed or misordered shift therefore appears within one cycle. A wrong counter stays hidden until that entry is selected again. The bench keeps every entry and the history in a behavioural model. It compares each guess against that model, and it steers the history back to entries it has trained, so a bad counter is seen on its next lookup.

// File: rtl/gh_pkg.sv
package gh_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/gh_history.sv
module gh_history #(
  parameter int HIST_LEN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [HIST_LEN-1:0] hist_o
);
  always_ff @(posedge clk) begin
    if (rst)           hist_o <= '0;
    else if (shift_en) hist_o <= {hist_o[HIST_LEN-2:0], bit_in};
  end
endmodule

// File: rtl/gh_table.sv
module gh_table
  import gh_pkg::*;
#(
  parameter int HIST_LEN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [HIST_LEN-1:0] rd_idx,
  output logic                rd_taken_o,
  input  logic                wr_en,
  input  logic [HIST_LEN-1:0] wr_idx,
  input  logic                wr_taken
);
  localparam int ENTRIES = 1 << HIST_LEN;

  ctr_t cells [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cells[e] <= CTR_RESET;
      else if (wr_en && (wr_idx == HIST_LEN'(e)))
        cells[e] <= ctr_train(cells[e], wr_taken);
    end
  end

  // Read sees the pre-write contents of the same edge.
  always_ff @(posedge clk) begin
    if (rst)        rd_taken_o <= 1'b0;
    else if (rd_en) rd_taken_o <= ctr_says_taken(cells[rd_idx]);
  end
endmodule

// File: rtl/gh_predictor.sv
module gh_predictor #(
  parameter int HIST_LEN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pred_req,
  output logic                pred_valid,
  output logic                pred_taken,
  output logic [HIST_LEN-1:0] pred_index,
  input  logic                res_valid,
  input  logic                res_taken,
  input  logic [HIST_LEN-1:0] res_index
);
  logic [HIST_LEN-1:0] ghr;

  gh_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk(clk), .rst(rst), .shift_en(res_valid), .bit_in(res_taken), .hist_o(ghr)
  );

  gh_table #(.HIST_LEN(HIST_LEN)) u_tbl (
    .clk(clk), .rst(rst),
    .rd_en(pred_req), .rd_idx(ghr), .rd_taken_o(pred_taken),
    .wr_en(res_valid), .wr_idx(res_index), .wr_taken(res_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_index <= '0;
    end else begin
      pred_valid <= pred_req;
      if (pred_req) pred_index <= ghr;
    end
  end
endmodule

// File: rtl/gh_predictor_chk.sv
module gh_predictor_chk #(
  parameter int HIST_LEN = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                pred_req,
  input logic                pred_valid,
  input logic [HIST_LEN-1:0] pred_index,
  input logic                res_valid,
  input logic                res_taken,
  input logic [HIST_LEN-1:0] hist
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    pred_req |=> pred_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !pred_req |=> !pred_valid);
  a_r6_index_is_hist: assert property (@(posedge clk) disable iff (rst)
    pred_req |=> pred_index == $past(hist));
  a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> hist == {$past(hist[HIST_LEN-2:0]), $past(res_taken)});
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(hist));
endmodule

bind gh_predictor gh_predictor_chk #(.HIST_LEN(HIST_LEN)) u_chk (
  .clk(clk), .rst(rst), .pred_req(pred_req), .pred_valid(pred_valid),
  .pred_index(pred_index), .res_valid(res_valid), .res_taken(res_taken),
  .hist(ghr)
);

// File: tb/gh_predictor_test.sv
module gh_predictor_test;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_req = 1'b0, res_valid = 1'b0, res_taken = 1'b0;
  logic [W-1:0] res_index = '0;
  logic pred_valid, pred_taken;
  logic [W-1:0] pred_index;

  int checks = 0, errors = 0;
  int m_tbl [N];
  int m_hist;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  gh_predictor #(.HIST_LEN(W)) uut (
    .clk(clk), .rst(rst), .pred_req(pred_req), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .pred_index(pred_index),
    .res_valid(res_valid), .res_taken(res_taken), .res_index(res_index)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, let a rising edge pass, compare at the next falling edge.
  task automatic step(input logic pr, input logic rv, input logic rt, input int ri, input string req);
    int ev, et, ei;
    pred_req = pr; res_valid = rv; res_taken = rt; res_index = W'(ri);
    ev = pr; et = 0; ei = 0;
    if (pr) begin et = (m_tbl[m_hist] >= 2); ei = m_hist; end   // R8: pre-update view
    if (rv) begin
      if (rt) m_tbl[ri] = (m_tbl[ri] == 3) ? 3 : m_tbl[ri] + 1;
      else    m_tbl[ri] = (m_tbl[ri] == 0) ? 0 : m_tbl[ri] - 1;
      m_hist = ((m_hist << 1) | int'(rt)) & (N - 1);
    end
    @(negedge clk);
    chk({req, " valid"}, int'(pred_valid), ev);
    if (pr) begin
      chk({req, " taken"}, int'(pred_taken), et);
      chk({req, " index"}, int'(pred_index), ei);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) m_tbl[i] = 1;
    m_hist = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: reset state
    step(1, 0, 0, 0, "R3");
    chk("R3 idx0", int'(pred_index), 0);
    chk("R3 not taken", int'(pred_taken), 0);
    step(0, 0, 0, 0, "R1");
    // R4/R9: train entry 0 up, then check it holds after one disagreement
    step(0, 1, 1, 0, "R4");
    step(0, 1, 1, 0, "R4");
    step(0, 1, 1, 0, "R4");
    step(0, 1, 1, 0, "R4");
    step(0, 1, 0, 0, "R9");
    for (int i = 0; i < W; i++) step(0, 1, 0, 5, "R5");
    step(1, 0, 0, 0, "R9");
    chk("R9 still taken", int'(pred_taken), 1);
    step(0, 1, 0, 0, "R9");
    for (int i = 0; i < W; i++) step(0, 1, 0, 5, "R5");
    step(1, 0, 0, 0, "R9");
    chk("R9 flipped", int'(pred_taken), 0);
    // R4: saturation at 0
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R4");
    step(0, 1, 1, 0, "R4");
    for (int i = 0; i < W; i++) step(0, 1, 0, 9, "R5");
    step(1, 0, 0, 0, "R4");
    chk("R4 floor", int'(pred_taken), 0);
    // R6: history 0x2E selects entry 46
    for (int b = W - 1; b >= 0; b--) step(0, 1, (8'h2E >> b) & 1, 7, "R5");
    step(1, 0, 0, 0, "R6");
    chk("R6 0x2E->46", int'(pred_index), 46);
    // R7/R8: same-cycle predict and resolve on a different index, then the current one
    step(1, 1, 1, 46, "R8");
    step(1, 1, 1, 3, "R7");
    step(1, 1, 1, m_hist, "R8");
    step(1, 0, 0, 0, "R2");
    // Mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] | lfsr[2], lfsr[3] | lfsr[4],
           lfsr[5] ? m_hist : int'(lfsr[15:8]), "R2");
    end
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule